// File: doc/BRIEF.md
# Guarded Mode Register with Operation Timer

This block holds the configuration word of a block-cipher engine and models how long the engine takes per block. The configuration word sits on a small register bus. A write only reaches it when the write-protect input is low. The very first write after reset must also carry an unlock code in its key nibble. Once a write has been accepted, later writes go through whatever the nibble holds.

The word holds four things: a tamper-clear enable, a 3-bit operating mode, and a 4-bit processing-delay value. The key nibble is the fourth field; it is never stored and always reads as zero. When the tamper-clear enable is set, a tamper pulse raises a key-wipe strobe in that same cycle. Counter mode (value 4) is the only defined mode. Writing a reserved mode is accepted but raises a mode-error flag, and start requests are then refused.

A start request in counter mode launches a timer. The timer keeps busy high for twelve cycles per delay step plus one, then pulses done for one cycle.

The timer is a three-state machine:
- IDLE goes to RUN on an accepted start.
- RUN counts down and goes to DONE when the count reaches zero.
- DONE always returns to IDLE.

Top module: `mode_reg_timer`

## Requirements
- R1: After reset the word at the mode address reads 0x00000004. busy, done, mode_err and key_clr are all low.
- R2: While wp_en is high, a write to the mode address leaves the readback unchanged.
- R3: On the first write after reset, a key nibble (bits 23:20) other than 0xE discards the whole write. A key nibble of 0xE lets the write through.
- R4: After one accepted write, later writes succeed with any key nibble. This permission ends only with reset.
- R5: Bits 23:20 always read as zero. The readback is {tamper enable in bit 31, mode in bits 14:12, delay in bits 7:4, 4'h4 in bits 3:0}, with every other bit zero.
- R6: When the stored bit 31 is 1, key_clr equals tamper_in in the same cycle. When bit 31 is 0, key_clr stays low.
- R7: An accepted write with a mode other than 4 sets mode_err, and start is then ignored. An accepted write of mode 4 clears mode_err.
- R8: A start sampled in IDLE with mode 4 sets busy from the next cycle, for exactly 12 × (delay + 1) cycles.
- R9: done is high for exactly one cycle, the cycle right after the last busy cycle.
- R10: A start in RUN or DONE is ignored. It neither stretches the current operation nor starts a new one.
- R11: The delay value is captured at start. A write to the word during RUN does not change the length of that operation.
- R12: Reads from any address other than the mode address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational on addr |
| wp_en | input | 1 | Write-protect enable |
| tamper_in | input | 1 | Tamper event, one-cycle active-high |
| start | input | 1 | Begin one block operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| key_clr | output | 1 | Key wipe strobe |
| mode_err | output | 1 | Reserved mode programmed |

## Verification
The hardest situations to reach are a start or a register write landing while an operation is already running. Both need a stimulus placed at a known cycle inside a 24-cycle window.

The operation task counts busy cycles at the falling edge. At a fixed count it injects either a second start or a rewrite of the delay value. It then checks that the measured length still matches the delay captured at launch. The password-once rule needs a second reset in the middle of the run, so that the unlock flag is observed to fall back.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } tmr_state_e;

    localparam int          TE_BIT    = 31;
    localparam int          KEY_LSB   = 20;
    localparam int          KEY_W     = 4;
    localparam int          MODE_LSB  = 12;
    localparam int          MODE_W    = 3;
    localparam int          DLY_LSB   = 4;
    localparam int          DLY_W     = 4;
    localparam logic [3:0]  UNLOCK    = 4'hE;
    localparam logic [2:0]  MODE_CTR  = 3'd4;
    localparam logic [3:0]  LOW_NIB   = 4'h4;
endpackage

// File: rtl/mrt_regs.sv
module mrt_regs
    import mrt_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int MODE_ADDR = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [31:0]         wr_data,
    input  logic                wp_en,
    output logic [31:0]         rd_data,
    output logic                tamper_en,
    output logic [MODE_W-1:0]   mode_q,
    output logic [DLY_W-1:0]    dly_q,
    output logic                mode_ok,
    output logic                mode_err
);
    localparam logic [ADDR_W-1:0] SEL = ADDR_W'(MODE_ADDR);

    logic unlocked;
    logic hit, key_ok, accept;
    logic [MODE_W-1:0] new_mode;

    always_comb begin
        hit      = wr_en && (addr == SEL);
        key_ok   = unlocked || (wr_data[KEY_LSB +: KEY_W] == UNLOCK);
        accept   = hit && !wp_en && key_ok;
        new_mode = wr_data[MODE_LSB +: MODE_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tamper_en <= 1'b0;
            mode_q    <= '0;
            dly_q     <= '0;
            unlocked  <= 1'b0;
            mode_err  <= 1'b0;
        end else if (accept) begin
            tamper_en <= wr_data[TE_BIT];
            mode_q    <= new_mode;
            dly_q     <= wr_data[DLY_LSB +: DLY_W];
            unlocked  <= 1'b1;
            mode_err  <= (new_mode != MODE_CTR);
        end
    end

    always_comb begin
        mode_ok = (mode_q == MODE_CTR);
        rd_data = '0;
        if (addr == SEL) begin
            rd_data[TE_BIT]                = tamper_en;
            rd_data[MODE_LSB +: MODE_W]    = mode_q;
            rd_data[DLY_LSB +: DLY_W]      = dly_q;
            rd_data[3:0]                   = LOW_NIB;
        end
    end
endmodule

// File: rtl/mrt_keywipe.sv
module mrt_keywipe (
    input  logic tamper_in,
    input  logic tamper_en,
    output logic key_clr
);
    always_comb key_clr = tamper_in && tamper_en;
endmodule

// File: rtl/mrt_timer.sv
module mrt_timer
    import mrt_pkg::*;
#(
    parameter int UNIT_CYCLES = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode_ok,
    input  logic [DLY_W-1:0] dly,
    output logic             busy,
    output logic             done
);
    localparam int MAX_CYC = UNIT_CYCLES * (2 ** DLY_W);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    tmr_state_e        state, nxt;
    logic [CNT_W-1:0]  cnt, cnt_nxt;
    logic [CNT_W-1:0]  load_val;

    always_comb load_val = CNT_W'(UNIT_CYCLES) * (CNT_W'(dly) + CNT_W'(1)) - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            ST_IDLE: if (start && mode_ok) begin
                nxt     = ST_RUN;
                cnt_nxt = load_val;
            end
            ST_RUN: if (cnt == '0) nxt = ST_DONE;
                    else cnt_nxt = cnt - CNT_W'(1);
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_RUN:  busy = 1'b1;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/mode_reg_timer.sv
module mode_reg_timer
    import mrt_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int MODE_ADDR   = 4,
    parameter int UNIT_CYCLES = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    input  logic              wp_en,
    input  logic              tamper_in,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              key_clr,
    output logic              mode_err
);
    logic              te_w;
    logic [MODE_W-1:0] mode_w;
    logic [DLY_W-1:0]  dly_w;
    logic              mode_ok_w;

    mrt_regs #(.ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .wp_en(wp_en), .rd_data(rd_data),
        .tamper_en(te_w), .mode_q(mode_w), .dly_q(dly_w),
        .mode_ok(mode_ok_w), .mode_err(mode_err)
    );

    mrt_keywipe u_wipe (
        .tamper_in(tamper_in), .tamper_en(te_w), .key_clr(key_clr)
    );

    mrt_timer #(.UNIT_CYCLES(UNIT_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_ok(mode_ok_w),
        .dly(dly_w), .busy(busy), .done(done)
    );
endmodule

// File: rtl/mrt_checker.sv
module mrt_checker
    import mrt_pkg::*;
#(
    parameter int MAX_RUN = 192
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp_en,
    input logic              tamper_in,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              key_clr,
    input logic              mode_err,
    input logic              te,
    input logic [MODE_W-1:0] mode_q,
    input logic [DLY_W-1:0]  dly_q
);
    int run_len;
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    assert_wp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wp_en |=> ($stable(mode_q) && $stable(dly_q) && $stable(te)));

    assert_wipe_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tamper_in && te) |-> key_clr);

    assert_wipe_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tamper_in || !te) |-> !key_clr);

    assert_err_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_err && !busy && !done) |=> !busy);

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(busy) && !busy));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    always_comb begin
        if (rst_n) assert_run_bound_R8: assert (run_len <= MAX_RUN);
    end
endmodule

bind mode_reg_timer mrt_checker #(.MAX_RUN(UNIT_CYCLES * 16)) u_chk (
    .clk(clk), .rst_n(rst_n), .wp_en(wp_en), .tamper_in(tamper_in),
    .start(start), .busy(busy), .done(done), .key_clr(key_clr),
    .mode_err(mode_err), .te(te_w), .mode_q(mode_w), .dly_q(dly_w)
);

// File: tb/test_mode_reg_timer.sv
module test_mode_reg_timer;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] MA = 4'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = MA;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        wp_en = 1'b0;
    logic        tamper_in = 1'b0;
    logic        start = 1'b0;
    logic        busy, done, key_clr, mode_err;

    int vectors = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mode_reg_timer i_mode_reg_timer (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .wp_en(wp_en), .tamper_in(tamper_in), .start(start),
        .busy(busy), .done(done), .key_clr(key_clr), .mode_err(mode_err)
    );

    function automatic logic [31:0] mk(input logic te, input logic [3:0] key,
                                       input logic [2:0] md, input logic [3:0] d);
        return {te, 7'b0, key, 5'b0, md, 4'b0, d, 4'b0};
    endfunction

    function automatic logic [31:0] img(input logic te, input logic [2:0] md, input logic [3:0] d);
        return {te, 16'b0, md, 4'b0, d, 4'h4};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk) begin addr = MA; wr_data = d; wr_en = 1'b1; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        addr = MA;
        #1;
        chk(rd_data == 32'h4, "R1 reset image", rd_data, 32'h4);
        chk({busy, done, mode_err, key_clr} == 4'b0, "R1 outputs low",
            {28'b0, busy, done, mode_err, key_clr}, 32'h0);
    endtask

    task automatic t_password();
        wr(mk(1'b0, 4'h3, 3'd4, 4'd5));
        chk(rd_data == 32'h4, "R3 wrong key rejected", rd_data, 32'h4);
        wr(mk(1'b0, 4'hE, 3'd4, 4'd5));
        chk(rd_data == img(1'b0, 3'd4, 4'd5), "R3 unlock accepted", rd_data, img(1'b0, 3'd4, 4'd5));
        chk(rd_data[23:20] == 4'h0, "R5 key nibble reads zero", {28'b0, rd_data[23:20]}, 32'h0);
        wr(mk(1'b0, 4'h0, 3'd4, 4'd2));
        chk(rd_data == img(1'b0, 3'd4, 4'd2), "R4 later write any key", rd_data, img(1'b0, 3'd4, 4'd2));
        do_reset();
        wr(mk(1'b0, 4'h1, 3'd4, 4'd7));
        chk(rd_data == 32'h4, "R4 unlock cleared by reset", rd_data, 32'h4);
        wr(mk(1'b0, 4'hE, 3'd4, 4'd1));
    endtask

    task automatic t_protect();
        wp_en = 1'b1;
        wr(mk(1'b1, 4'hE, 3'd4, 4'd9));
        chk(rd_data == img(1'b0, 3'd4, 4'd1), "R2 write blocked", rd_data, img(1'b0, 3'd4, 4'd1));
        wp_en = 1'b0;
    endtask

    task automatic t_other_addr();
        @(negedge clk) addr = 4'd0;
        #1 chk(rd_data == 32'h0, "R12 other address", rd_data, 32'h0);
        addr = 4'd9;
        #1 chk(rd_data == 32'h0, "R12 other address", rd_data, 32'h0);
        addr = MA;
    endtask

    task automatic t_tamper();
        wr(mk(1'b1, 4'h0, 3'd4, 4'd1));
        chk(rd_data == img(1'b1, 3'd4, 4'd1), "R5 image with enable", rd_data, img(1'b1, 3'd4, 4'd1));
        @(negedge clk) tamper_in = 1'b1;
        #1 chk(key_clr == 1'b1, "R6 wipe when enabled", {31'b0, key_clr}, 32'h1);
        @(negedge clk) tamper_in = 1'b0;
        #1 chk(key_clr == 1'b0, "R6 strobe single", {31'b0, key_clr}, 32'h0);
        wr(mk(1'b0, 4'h0, 3'd4, 4'd1));
        @(negedge clk) tamper_in = 1'b1;
        #1 chk(key_clr == 1'b0, "R6 no wipe when disabled", {31'b0, key_clr}, 32'h0);
        @(negedge clk) tamper_in = 1'b0;
    endtask

    task automatic t_mode_err();
        wr(mk(1'b0, 4'h0, 3'd2, 4'd0));
        chk(mode_err == 1'b1, "R7 reserved mode flagged", {31'b0, mode_err}, 32'h1);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b0, "R7 start refused", {31'b0, busy}, 32'h0);
        wr(mk(1'b0, 4'h0, 3'd4, 4'd0));
        chk(mode_err == 1'b0, "R7 mode 4 clears flag", {31'b0, mode_err}, 32'h0);
    endtask

    task automatic run_op(input int n, input bit poke, input bit rewrite, input string req);
        int cnt;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, {req, " busy after start"}, {31'b0, busy}, 32'h1);
        cnt = 1;
        while (busy && cnt < 400) begin
            start = (poke && cnt == 3);
            wr_en = (rewrite && cnt == 3);
            wr_data = mk(1'b0, 4'h0, 3'd4, 4'd0);
            @(negedge clk);
            if (busy) cnt++;
        end
        start = 1'b0;
        wr_en = 1'b0;
        chk(cnt == n, req, cnt, n);
        chk(done == 1'b1, "R9 done after last busy", {31'b0, done}, 32'h1);
        if (poke) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(done == 1'b0, "R9 done one cycle", {31'b0, done}, 32'h0);
        chk(busy == 1'b0, "R10 no restart from done", {31'b0, busy}, 32'h0);
    endtask

    initial begin
        t_reset();
        t_password();
        t_protect();
        t_other_addr();
        t_tamper();
        t_mode_err();
        run_op(12, 1'b0, 1'b0, "R8 delay 0 length");
        wr(mk(1'b0, 4'h0, 3'd4, 4'd3));
        run_op(48, 1'b0, 1'b0, "R8 delay 3 length");
        wr(mk(1'b0, 4'h0, 3'd4, 4'd1));
        run_op(24, 1'b1, 1'b0, "R10 start during run");
        run_op(24, 1'b0, 1'b1, "R11 delay captured");
        chk(rd_data == img(1'b0, 3'd4, 4'd0), "R11 rewrite landed", rd_data, img(1'b0, 3'd4, 4'd0));
        run_op(12, 1'b0, 1'b0, "R11 new delay next op");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        vectors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule